// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an internal single-word request port and an external byte-wide asynchronous static memory that holds 128K words of 8 bits. It converts each accepted read or write into a sequence of active-low chip-select, write-strobe and output-strobe levels, all derived from the system clock. The minimum access and cycle times are given in nanoseconds as parameters and rounded up to whole clock cycles.

The shared data bus appears as three signals: data out, data in and a drive enable. The controller drives the bus only while the memory's outputs are switched off. The last cycle of every read disables the memory's outputs, so a write that follows cannot collide with read data. When no request is pending, chip select is released and the memory stays in standby.

A write ends when the write strobe rises. Address and data stay stable through that edge and for one more clock. Read data is captured on the last clock of the access window. A one-cycle acknowledge marks both completions.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset, chip select, write strobe and output strobe are high (1), bus drive enable is 0, `req_ready` is 1 and `ack` is 0.
- R2: While the controller is idle, `req_ready` is 1, chip select is high and the bus is not driven. A request is accepted at a rising clock edge where `req_valid` and `req_ready` are both 1.
- R3: A read holds chip select and output strobe low and write strobe high for ACC_CYC cycles, with the address stable. Read data is captured at the end of the last of those cycles. `ack` is high for exactly one cycle, with the captured data on `rdata`. At default parameters, `ack` is seen 4 clocks after the accepting edge.
- R4: A write drives the bus for one cycle with both strobes high. It then holds the write strobe low for ACC_CYC cycles. After the write strobe rises it keeps address and data driven for one more cycle, with `ack` high in that cycle. At defaults, `ack` is seen 5 clocks after the accepting edge.
- R5: The bus drive enable is never 1 while the output strobe is low. Output strobe and write strobe are never low together. The write strobe is low only while the bus is driven.
- R6: A read ends with one turnaround cycle in which chip select is low, both strobes are high and the bus is not driven. The controller then returns to idle.
- R7: `req_ready` is 0 from the accepting edge until the controller is idle again. Requests presented during that time are not taken, and the memory address does not change.
- R8: ACC_CYC = ceil(T_ACCESS_NS / CLK_PERIOD_NS) and OE_CYC = ceil(T_OE_NS / CLK_PERIOD_NS). The read window is the larger of the two. At the defaults (4 ns clock, 10 ns and 5 ns) the window is 3 cycles.
- R9: Data written to any 17-bit address, including 0x00000 and 0x1FFFF, reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle, request can be taken |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read data |
| mem_addr | output | 17 | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_in | input | 8 | Data received from the memory |

## Verification
The bench's memory model returns a poison byte (0xEE) until its outputs have been enabled for a full access window. A read window that is too short therefore shows up as wrong read data. A write whose strobe stays low for too short a time stores the corrupt byte 0xBD. A write whose data is gone when the strobe rises stores the wrong value. The model also flags any cycle where the controller and the memory drive the bus together, for example a write that starts during a read with no turnaround. A write followed at once by a read, the highest and lowest addresses, and a request held during a busy transfer are tested. These cases catch a missing hold cycle, a missing turnaround and a request accepted too early.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int AW            = 17,
  parameter int DW            = 8,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_ACCESS_NS   = 10,
  parameter int T_OE_NS       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int ACC_CYC = (T_ACCESS_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int OE_CYC  = (T_OE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int RD_CYC  = (ACC_CYC > OE_CYC) ? ACC_CYC : OE_CYC;
  localparam int WR_CYC  = ACC_CYC;
  localparam int MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_RD_OFF, S_WR_SET, S_WR, S_WR_HOLD
  } state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;

  wire rd_last = (cnt == CNT_W'(RD_CYC - 1));
  wire wr_last = (cnt == CNT_W'(WR_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      ack     <= 1'b0;
    end else begin
      ack <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          cnt     <= '0;
          state   <= req_write ? S_WR_SET : S_RD;
        end
        S_RD: begin
          cnt <= cnt + 1'b1;
          if (rd_last) begin
            rdata <= mem_dq_in;
            ack   <= 1'b1;
            state <= S_RD_OFF;
          end
        end
        S_RD_OFF:  state <= S_IDLE;
        S_WR_SET:  state <= S_WR;
        S_WR: begin
          cnt <= cnt + 1'b1;
          if (wr_last) begin
            ack   <= 1'b1;
            state <= S_WR_HOLD;
          end
        end
        S_WR_HOLD: state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign mem_ce_n   = (state == S_IDLE);
  assign mem_oe_n   = (state != S_RD);
  assign mem_we_n   = (state != S_WR);
  assign mem_dq_oe  = (state == S_WR_SET) || (state == S_WR) || (state == S_WR_HOLD);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          ack,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);
  p_idle_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !req_ready && !$past(req_ready)) |-> $stable(mem_addr));

  p_we_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) && !mem_ce_n) |-> (mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr)));

  p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe));

  p_read_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));
endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .DW(DW)) u_sram_ctrl_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ack(ack),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctrl_bench.sv
module sram_ctrl_bench;
  localparam int ACC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, ack;
  logic [7:0]  rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sram_ctrl u_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .ack(ack), .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Behavioural memory model
  logic [7:0] mdl [logic [16:0]];
  int   age = 0, we_low = 0, oe_low = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1;
  wire  mdl_drv = rst_n && !mem_ce_n && !mem_oe_n && mem_we_n;
  wire [7:0] mdl_val = mdl.exists(mem_addr) ? mdl[mem_addr] : 8'h77;
  assign mem_dq_in = mdl_drv ? ((age >= ACC) ? mdl_val : 8'hEE) : 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (mem_dq_oe && mdl_drv) check(0, "R5 bus contention", 1, 0);
    if (!mem_we_n && !mem_oe_n) check(0, "R5 strobes both low", 0, 1);
    if (mem_ce_n && (!mem_we_n || !mem_oe_n)) check(0, "R2 strobe without select", 0, 1);
    if (prev_we == 1'b0 && mem_we_n) begin
      check(we_low == ACC, "R8 write strobe length", we_low, ACC);
      mdl[mem_addr] = (we_low >= ACC && mem_dq_oe) ? mem_dq_out : 8'hBD;
    end
    if (prev_oe == 1'b0 && mem_oe_n)
      check(oe_low == ACC, "R8 read window length", oe_low, ACC);
    we_low  = mem_we_n ? 0 : we_low + 1;
    oe_low  = mem_oe_n ? 0 : oe_low + 1;
    age     = mdl_drv ? age + 1 : 0;
    prev_we = mem_we_n;
    prev_oe = mem_oe_n;
  end

  task automatic xfer(input logic w, input logic [16:0] a, input logic [7:0] d,
                      output logic [7:0] rd, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!ack && lat < 50) begin @(negedge clk); lat++; end
    rd = rdata;
    if (!w) check(!mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R6 turnaround",
                  {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0110);
    else check(mem_dq_oe && mem_we_n && mem_addr == a && mem_dq_out == d, "R4 hold cycle",
               {mem_dq_oe, mem_we_n}, 2'b11);
    @(negedge clk);
    check(!ack, "R3 ack single pulse", ack, 0);
  endtask

  // {write, addr, data, expected}
  localparam logic [33:0] VEC [10] = '{
    {1'b1, 17'h00000, 8'hA5, 8'h00},
    {1'b1, 17'h1FFFF, 8'h5A, 8'h00},
    {1'b1, 17'h00001, 8'h3C, 8'h00},
    {1'b0, 17'h00000, 8'h00, 8'hA5},
    {1'b0, 17'h1FFFF, 8'h00, 8'h5A},
    {1'b1, 17'h00000, 8'hFF, 8'h00},
    {1'b0, 17'h00000, 8'h00, 8'hFF},
    {1'b0, 17'h00001, 8'h00, 8'h3C},
    {1'b1, 17'h10000, 8'h00, 8'h00},
    {1'b0, 17'h10000, 8'h00, 8'h00}
  };

  initial begin
    logic [7:0] rd;
    int lat;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !ack,
          "R1 reset state", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, ack}, 6'b111010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready && mem_ce_n && !mem_dq_oe, "R2 idle standby",
          {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);

    for (int i = 0; i < 10; i++) begin
      xfer(VEC[i][33], VEC[i][32:16], VEC[i][15:8], rd, lat);
      if (VEC[i][33]) check(lat == 5, "R4 write latency", lat, 5);
      else begin
        check(lat == 4, "R3 read latency", lat, 4);
        check(rd == VEC[i][7:0], "R9 read-after-write data", rd, VEC[i][7:0]);
      end
    end

    // R7: request held during a busy read is not taken
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h1FFFF;
    @(negedge clk);
    req_write = 1'b1; req_addr = 17'h00001; req_wdata = 8'h99;
    check(!req_ready, "R7 ready low when busy", req_ready, 0);
    @(negedge clk);
    check(mem_addr == 17'h1FFFF && mem_we_n, "R7 busy request ignored", mem_addr, 17'h1FFFF);
    while (!ack) @(negedge clk);
    check(rdata == 8'h5A, "R3 read data with ack", rdata, 8'h5A);
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    xfer(1'b0, 17'h00001, 8'h00, rd, lat);
    check(rd == 8'h3C, "R7 location untouched by held request", rd, 8'h3C);

    // back-to-back write then read, then write after read
    xfer(1'b1, 17'h0ABCD, 8'h6E, rd, lat);
    xfer(1'b0, 17'h0ABCD, 8'h00, rd, lat);
    check(rd == 8'h6E, "R9 write then read", rd, 8'h6E);
    xfer(1'b1, 17'h0ABCD, 8'h81, rd, lat);
    xfer(1'b0, 17'h0ABCD, 8'h00, rd, lat);
    check(rd == 8'h81, "R5 read write read no contention", rd, 8'h81);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule